// File: doc/BRIEF.md
# Video Gain and Black-Level Loop Controller

This block holds the digital decision logic that sits behind a video digitizer. Every sample clock it receives the converter's 8-bit code and its underflow and overflow flags. It also receives two timing strobes from the sync separator. The first strobe is high across the sync tip. The second is high across the back porch. From these it computes two small signed commands. One drives the charge pump that sets amplifier gain. The other drives the charge pump that sets the black-level clamp.

Two acquisition modes exist. In the coarse mode, the loops run on every sample with large steps, so that a weak or badly offset signal is pulled into range quickly. When a sync strobe of adequate width is followed by a back-porch strobe of adequate width, the block moves to the fine mode. In the fine mode, gain is regulated only at the sync tip, aiming for code 0. The clamp is regulated only at the back porch, aiming for code 64. A white-peak limit at code 248 overrides every other gain request. If no complete strobe pair arrives for a set number of lines, the block falls back to coarse mode.

Top module: `video_agc_clamp`

## Requirements
- R1: After reset the block is in coarse mode (`fineMode` = 0) and both commands are hold (0).
- R2: Each command is a 3-bit two's complement value: 0 hold, ±1 small, ±2 medium, ±3 large. A positive value raises gain or raises the black level. Each command is registered and appears on the clock edge that samples the inputs it reflects.
- R3: In coarse mode the gain command is -3 when `overFlag` is set and -1 otherwise, whatever the strobes are.
- R4: In coarse mode the clamp command is +3 when `underFlag` is set. It is -1 for any nonzero code, and 0 for code 0 without underflow, whatever the strobes are.
- R5: A strobe pulse is valid only if it stays high for at least MIN_PULSE consecutive samples. The default is 64, which is 2 µs at 32 MHz. A shorter pulse has no effect on the mode.
- R6: Fine mode is entered on the sample where a valid back-porch pulse ends, and only if a valid sync pulse ended before it. A back-porch pulse with no preceding valid sync pulse does not change the mode.
- R7: In fine mode, a code above 248 or a set `overFlag` makes the gain command -3, with or without strobes.
- R8: In fine mode, while the sync strobe is high and no peak condition applies, the gain command is as follows. It is +1 on underflow. It is -1 for codes 1 to 248. It is 0 for code 0 without underflow.
- R9: In fine mode, while the back-porch strobe is high, the clamp command is as follows. It is +2 for codes below 64 or on underflow. It is -2 for codes above 64. It is 0 at exactly 64.
- R10: In fine mode, the clamp command is 0 whenever the back-porch strobe is low. The gain command is 0 when the sync strobe is low and no peak condition applies.
- R11: Fine mode returns to coarse after LINE_CLKS × LOSS_LINES samples pass without a complete valid pair. Each complete pair restarts that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sampleCode | input | CODE_W | Converter output code |
| underFlag | input | 1 | Converter input below the bottom of range |
| overFlag | input | 1 | Converter input above the top of range |
| syncGate | input | 1 | High during the sync tip |
| porchGate | input | 1 | High during the back porch |
| gainCmd | output | 3 | Signed gain pump command |
| clampCmd | output | 3 | Signed clamp pump command |
| fineMode | output | 1 | 1 in fine mode, 0 in coarse mode |

## Verification
The hardest state to reach is the armed-but-not-locked condition. In that state a valid sync pulse has been seen, but the back-porch pulse that would complete the pair has not. The stimulus brings it about in several ways. It sends pulses one sample short of the minimum. It sends the strobes in the wrong order. It sends a valid sync followed by a short porch. After each of these it checks that the mode has not changed. Only then does a valid porch pulse complete the pair. The loss window is exercised twice. In the first run, the window is left to expire. In the second, a fresh pair arrives partway through and restarts the window.

// File: rtl/vac_pkg.sv
package vac_pkg;

  typedef logic [2:0] cmd_t;

  localparam cmd_t CMD_HOLD = 3'b000;
  localparam cmd_t CMD_UP1  = 3'b001;
  localparam cmd_t CMD_UP2  = 3'b010;
  localparam cmd_t CMD_UP3  = 3'b011;
  localparam cmd_t CMD_DN1  = 3'b111;
  localparam cmd_t CMD_DN2  = 3'b110;
  localparam cmd_t CMD_DN3  = 3'b101;

  typedef enum logic {
    MODE_COARSE = 1'b0,
    MODE_FINE   = 1'b1
  } acqMode_t;

  typedef struct packed {
    logic fine;
    logic syncOn;
    logic porchOn;
  } ctrlStrobes_t;

endpackage

// File: rtl/vac_pulse_qual.sv
module vac_pulse_qual #(
  parameter int MIN_PULSE = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gateIn,
  output logic validEnd
);

  localparam int CNT_W = $clog2(MIN_PULSE + 1);
  localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_PULSE);

  logic [CNT_W-1:0] widthCnt;
  logic             gatePrev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      widthCnt <= '0;
      gatePrev <= 1'b0;
    end else begin
      gatePrev <= gateIn;
      if (!gateIn)
        widthCnt <= '0;
      else if (widthCnt != MIN_C)
        widthCnt <= widthCnt + 1'b1;
    end
  end

  assign validEnd = gatePrev & ~gateIn & (widthCnt == MIN_C);

  AST_SAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    widthCnt <= MIN_C) else $error("width counter overran");  // R5

endmodule

// File: rtl/vac_mode_ctrl.sv
module vac_mode_ctrl
  import vac_pkg::*;
#(
  parameter int MIN_PULSE  = 64,
  parameter int LINE_CLKS  = 2048,
  parameter int LOSS_LINES = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         syncGate,
  input  logic         porchGate,
  output ctrlStrobes_t strobes
);

  localparam int TIMEOUT = LINE_CLKS * LOSS_LINES;
  localparam int TMR_W   = $clog2(TIMEOUT + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT - 1);

  logic [1:0] gateBus;
  logic [1:0] gateValid;

  assign gateBus = {porchGate, syncGate};

  for (genvar g = 0; g < 2; g++) begin : g_qual
    vac_pulse_qual #(.MIN_PULSE(MIN_PULSE)) u_qual (
      .clk     (clk),
      .rst_n   (rst_n),
      .gateIn  (gateBus[g]),
      .validEnd(gateValid[g])
    );
  end

  logic syncValid, porchValid, armed, pairDone;
  acqMode_t modeQ;
  logic [TMR_W-1:0] lossTmr;

  assign syncValid  = gateValid[0];
  assign porchValid = gateValid[1];
  assign pairDone   = porchValid & armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      modeQ   <= MODE_COARSE;
      lossTmr <= '0;
    end else begin
      if (syncValid)
        armed <= 1'b1;
      else if (porchValid)
        armed <= 1'b0;

      case (modeQ)
        MODE_COARSE: begin
          lossTmr <= '0;
          if (pairDone) modeQ <= MODE_FINE;
        end
        default: begin
          if (pairDone) begin
            lossTmr <= '0;
          end else if (lossTmr == TMR_LAST) begin
            lossTmr <= '0;
            modeQ   <= MODE_COARSE;
          end else begin
            lossTmr <= lossTmr + 1'b1;
          end
        end
      endcase
    end
  end

  assign strobes.fine    = (modeQ == MODE_FINE);
  assign strobes.syncOn  = syncGate;
  assign strobes.porchOn = porchGate;

  AST_LOCK_NEEDS_PORCH: assert property (@(posedge clk) disable iff (!rst_n)
    (modeQ == MODE_COARSE && !porchValid) |=> modeQ == MODE_COARSE)
    else $error("fine mode entered without porch pulse");  // R6

  AST_LOCK_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (modeQ == MODE_COARSE && !armed) |=> modeQ == MODE_COARSE)
    else $error("fine mode entered without prior sync");  // R6

  AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    lossTmr <= TMR_LAST) else $error("loss timer overran");  // R11

endmodule

// File: rtl/vac_cmd_path.sv
module vac_cmd_path
  import vac_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int PEAK_LIMIT  = 248,
  parameter int BLACK_LEVEL = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      strobes,
  input  logic [CODE_W-1:0] sampleCode,
  input  logic              underFlag,
  input  logic              overFlag,
  output cmd_t              gainCmd,
  output cmd_t              clampCmd
);

  localparam logic [CODE_W-1:0] PEAK_C  = CODE_W'(PEAK_LIMIT);
  localparam logic [CODE_W-1:0] BLACK_C = CODE_W'(BLACK_LEVEL);

  logic codeZero, peakHit, belowBlack, aboveBlack;
  cmd_t gainNext, clampNext;

  assign codeZero   = (sampleCode == '0);
  assign peakHit    = overFlag | (sampleCode > PEAK_C);
  assign belowBlack = underFlag | (sampleCode < BLACK_C);
  assign aboveBlack = overFlag | (sampleCode > BLACK_C);

  always_comb begin
    gainNext  = CMD_HOLD;
    clampNext = CMD_HOLD;
    if (!strobes.fine) begin
      gainNext = overFlag ? CMD_DN3 : CMD_DN1;
      if (underFlag)      clampNext = CMD_UP3;
      else if (!codeZero) clampNext = CMD_DN1;
    end else begin
      if (peakHit)
        gainNext = CMD_DN3;
      else if (strobes.syncOn) begin
        if (underFlag)      gainNext = CMD_UP1;
        else if (!codeZero) gainNext = CMD_DN1;
      end
      if (strobes.porchOn) begin
        if (aboveBlack)      clampNext = CMD_DN2;
        else if (belowBlack) clampNext = CMD_UP2;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gainCmd  <= CMD_HOLD;
      clampCmd <= CMD_HOLD;
    end else begin
      gainCmd  <= gainNext;
      clampCmd <= clampNext;
    end
  end

  AST_PEAK_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.fine && (overFlag || sampleCode > PEAK_C)) |=> gainCmd == CMD_DN3)
    else $error("peak limit not applied");  // R7

  AST_CLAMP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.fine && !strobes.porchOn) |=> clampCmd == CMD_HOLD)
    else $error("clamp active outside porch");  // R10

  AST_COARSE_GAIN_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.fine |=> gainCmd[2])
    else $error("coarse gain not reducing");  // R3

  AST_NO_MIN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    gainCmd != 3'b100 && clampCmd != 3'b100)
    else $error("unused command code");  // R2

endmodule

// File: rtl/video_agc_clamp.sv
module video_agc_clamp
  import vac_pkg::*;
#(
  parameter int CODE_W      = 8,
  parameter int PEAK_LIMIT  = 248,
  parameter int BLACK_LEVEL = 64,
  parameter int MIN_PULSE   = 64,
  parameter int LINE_CLKS   = 2048,
  parameter int LOSS_LINES  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] sampleCode,
  input  logic              underFlag,
  input  logic              overFlag,
  input  logic              syncGate,
  input  logic              porchGate,
  output logic [2:0]        gainCmd,
  output logic [2:0]        clampCmd,
  output logic              fineMode
);

  ctrlStrobes_t strobes;
  cmd_t gainInt, clampInt;

  vac_mode_ctrl #(
    .MIN_PULSE (MIN_PULSE),
    .LINE_CLKS (LINE_CLKS),
    .LOSS_LINES(LOSS_LINES)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .syncGate (syncGate),
    .porchGate(porchGate),
    .strobes  (strobes)
  );

  vac_cmd_path #(
    .CODE_W     (CODE_W),
    .PEAK_LIMIT (PEAK_LIMIT),
    .BLACK_LEVEL(BLACK_LEVEL)
  ) u_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .sampleCode(sampleCode),
    .underFlag (underFlag),
    .overFlag  (overFlag),
    .gainCmd   (gainInt),
    .clampCmd  (clampInt)
  );

  assign gainCmd  = gainInt;
  assign clampCmd = clampInt;
  assign fineMode = strobes.fine;

  AST_RESET_HOLD: assert property (@(posedge clk)
    !rst_n |=> (gainCmd == 3'b000 && clampCmd == 3'b000 && !fineMode))
    else $error("reset state wrong");  // R1

endmodule

// File: tb/video_agc_clamp_tb.sv
`timescale 1ns/1ps
module video_agc_clamp_tb;

  localparam int MINP = 8;
  localparam int LCLK = 32;
  localparam int LOSS = 4;
  localparam int TOUT = LCLK * LOSS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sampleCode = '0;
  logic       underFlag = 1'b0, overFlag = 1'b0;
  logic       syncGate = 1'b0, porchGate = 1'b0;
  logic [2:0] gainCmd, clampCmd;
  logic       fineMode;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  video_agc_clamp #(
    .MIN_PULSE(MINP), .LINE_CLKS(LCLK), .LOSS_LINES(LOSS)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .sampleCode(sampleCode),
    .underFlag(underFlag), .overFlag(overFlag),
    .syncGate(syncGate), .porchGate(porchGate),
    .gainCmd(gainCmd), .clampCmd(clampCmd), .fineMode(fineMode)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sx(input logic [2:0] v);
    return (v[2]) ? int'(v) - 8 : int'(v);
  endfunction

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0; syncGate = 0; porchGate = 0;
    underFlag = 0; overFlag = 0; sampleCode = 8'd0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drive one sample, then look at the commands it produced
  task automatic sample(input logic [7:0] c, input logic u, input logic o,
                        input logic sg, input logic pg,
                        input int expG, input int expC, input string req);
    @(negedge clk);
    sampleCode = c; underFlag = u; overFlag = o; syncGate = sg; porchGate = pg;
    @(posedge clk); #1;
    check({req, " gain"}, sx(gainCmd), expG);
    check({req, " clamp"}, sx(clampCmd), expC);
  endtask

  task automatic pulse(input bit isPorch, input int len);
    @(negedge clk);
    sampleCode = 8'd64; underFlag = 0; overFlag = 0;
    if (isPorch) porchGate = 1'b1; else syncGate = 1'b1;
    repeat (len) @(negedge clk);
    syncGate = 1'b0; porchGate = 1'b0;
    @(negedge clk);
  endtask

  task automatic lockPair();
    pulse(1'b0, MINP);
    pulse(1'b1, MINP);
  endtask

  task automatic testReset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 gain", sx(gainCmd), 0);
    check("R1 clamp", sx(clampCmd), 0);
    check("R1 mode", fineMode, 0);
    rst_n = 1'b1;
  endtask

  task automatic testCoarse();
    doReset();
    sample(8'd100, 0, 0, 0, 0, -1, -1, "R3 R4 mid code");
    sample(8'd255, 0, 1, 1, 0, -3, -1, "R3 overflow");
    sample(8'd0,   1, 0, 0, 1, -1,  3, "R4 underflow");
    sample(8'd0,   0, 0, 0, 0, -1,  0, "R4 zero code");
    sample(8'd255, 0, 0, 0, 0, -1, -1, "R3 full scale no flag");
    check("R2 still coarse", fineMode, 0);
  endtask

  task automatic testQualify();
    doReset();
    pulse(1'b1, MINP);
    check("R6 porch alone", fineMode, 0);
    pulse(1'b0, MINP - 1);
    pulse(1'b1, MINP);
    check("R5 short sync", fineMode, 0);
    pulse(1'b0, MINP);
    pulse(1'b1, MINP - 1);
    check("R5 short porch", fineMode, 0);
    pulse(1'b1, MINP);
    check("R6 valid pair", fineMode, 1);
  endtask

  task automatic testFineGain();
    doReset();
    lockPair();
    check("R6 locked", fineMode, 1);
    sample(8'd100, 0, 0, 0, 0,  0, 0, "R10 idle");
    sample(8'd248, 0, 0, 0, 0,  0, 0, "R10 at peak limit");
    sample(8'd249, 0, 0, 0, 0, -3, 0, "R7 above limit idle");
    sample(8'd250, 0, 0, 1, 0, -3, 0, "R7 peak in sync");
    sample(8'd255, 0, 1, 0, 0, -3, 0, "R7 overflow");
    sample(8'd0,   1, 0, 1, 0,  1, 0, "R8 underflow");
    sample(8'd10,  0, 0, 1, 0, -1, 0, "R8 low code");
    sample(8'd248, 0, 0, 1, 0, -1, 0, "R8 limit code");
    sample(8'd0,   0, 0, 1, 0,  0, 0, "R8 zero");
    sample(8'd0,   1, 0, 0, 0,  0, 0, "R10 underflow idle");
  endtask

  task automatic testFineClamp();
    doReset();
    lockPair();
    sample(8'd30,  0, 0, 0, 1, 0,  2, "R9 below black");
    sample(8'd63,  0, 0, 0, 1, 0,  2, "R9 just below");
    sample(8'd64,  0, 0, 0, 1, 0,  0, "R9 at black");
    sample(8'd65,  0, 0, 0, 1, 0, -2, "R9 just above");
    sample(8'd0,   1, 0, 0, 1, 0,  2, "R9 underflow");
    sample(8'd250, 0, 0, 0, 1, -3, -2, "R7 R9 peak in porch");
    sample(8'd30,  0, 0, 0, 0, 0,  0, "R10 porch off");
    @(negedge clk); porchGate = 0;
  endtask

  task automatic testTimeout();
    doReset();
    lockPair();
    repeat (TOUT - 2) @(negedge clk);
    check("R11 before expiry", fineMode, 1);
    repeat (3) @(negedge clk);
    check("R11 expired", fineMode, 0);
    lockPair();
    check("R11 relock", fineMode, 1);
    repeat (TOUT / 2) @(negedge clk);
    lockPair();
    repeat (TOUT - 4) @(negedge clk);
    check("R11 window restarted", fineMode, 1);
    repeat (8) @(negedge clk);
    check("R11 expired again", fineMode, 0);
  endtask

  initial begin
    #(5.0 * 20000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    testReset();
    testCoarse();
    testQualify();
    testFineGain();
    testFineClamp();
    testTimeout();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule